// File: doc/BRIEF.md
# Instruction Head Parser

The block reads the leading bytes of an x86 instruction from a byte stream, one byte per accepted transfer. It steps over legacy prefixes, an optional REX byte in long mode, an optional two- or three-byte VEX or four-byte EVEX prefix, and the 0F / 0F 38 / 0F 3A escape bytes. It stops on the primary opcode byte. It then presents one result: a prefix summary, the extension bits, the vector fields, the opcode map, the opcode byte and the number of bytes consumed, which is the offset of the ModR/M byte. It also carries flags for repeated prefix groups, illegal prefix mixes and over-long instructions.

Outside long mode, the bytes C4, C5 and 62 are ambiguous. The parser accepts the following byte and checks its top two bits. The value 11 selects the vector prefix. Any other value means the first byte was the opcode (LES, LDS or BOUND), and the byte just taken was its ModR/M. That case is reported with `modrm_taken`, and the ModR/M byte is not counted in `byte_count`.

Back-pressure rules: `in_ready` is high in every cycle except the single cycle in which `done` is high. A byte transfers on a rising edge when `in_valid` and `in_ready` are both high. `in_valid` may drop between bytes with no effect. `long_mode` must stay constant from the first byte of an instruction until its `done` cycle.

Top module: `insn_head_parser`

## Requirements
- R1: After the rising edge that accepts the byte ending the parse, `done` is high for exactly one cycle. `in_ready` is low only in that cycle, and no byte is accepted during it.
- R2: Legacy prefixes are summarised as follows. `lockrep_sel` is 1 for F0, 2 for F2, 3 for F3 and 0 for none. `seg_sel` is 1 for 26, 2 for 2E, 3 for 36, 4 for 3E, 5 for 64, 6 for 65 and 0 for none. `opsize_ovr` flags 66 and `addrsize_ovr` flags 67.
- R3: When the lock/repeat group or the segment group appears twice or more, the last byte of that group is reported and `multi_pfx` is set.
- R4: In long mode, a byte 40–4F after the legacy prefixes sets `rex_present`, with W,R,X,B taken from bits 3..0. A legacy prefix after it discards it. Outside long mode, such a byte is the opcode.
- R5: `op_map` is 0 for a one-byte opcode, 1 after 0F, 2 after 0F 38 and 3 after 0F 3A. `opcode` is the byte that ends the parse.
- R6: In long mode, C4, C5 and 62 always start a vector prefix, and `enc_kind` is 1 for VEX or 2 for EVEX. A C5 prefix has one payload byte: R is the inverted bit 7, vvvv is the inverted bits 6..3, L is bit 2, and the map is 1.
- R7: A C4 prefix has two payload bytes. In the first, R, X and B are the inverted bits 7..5 and the map is bits 4..0; a map outside 1..3 sets `bad_enc`. In the second, W is bit 7, vvvv is the inverted bits 6..3 and L is bit 2. An EVEX prefix has three payload bytes. The first holds the inverted R, X and B in bits 7..5 and the map in bits 1..0; a map of 0 is bad. The second holds W in bit 7 and the inverted vvvv in bits 6..3. The third holds the vector length in bits 6..5.
- R8: Outside long mode, if the byte after C4, C5 or 62 has bits 7..6 not equal to 11, that lead byte is the opcode. In that case `op_map` is 0, `enc_kind` is 0 and `modrm_taken` is 1.
- R9: A vector prefix preceded by REX, F0, F2, F3 or 66 sets `bad_enc`.
- R10: If the 15th accepted byte does not end the parse, the parse stops with `len_fault` set and `byte_count` equal to 15.
- R11: `byte_count` is the number of bytes accepted up to and including the opcode, excluding a ModR/M byte taken by the look-ahead.
- R12: A synchronous reset, even in the middle of an instruction, returns the block to an empty parse with `in_ready` high and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| long_mode | input | 1 | High when the 64-bit long mode rules apply |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | 8 | Instruction byte |
| done | output | 1 | One-cycle pulse: result ports are valid |
| opcode | output | 8 | Primary opcode byte |
| op_map | output | 2 | Opcode map code |
| enc_kind | output | 2 | 0 legacy, 1 VEX, 2 EVEX |
| byte_count | output | 4 | Bytes consumed through the opcode |
| modrm_taken | output | 1 | Look-ahead consumed the ModR/M byte |
| lockrep_sel | output | 2 | Effective lock/repeat prefix |
| seg_sel | output | 3 | Effective segment override |
| opsize_ovr | output | 1 | 66 seen |
| addrsize_ovr | output | 1 | 67 seen |
| rex_present | output | 1 | A valid REX byte is in effect |
| ext_w | output | 1 | W bit from REX, VEX or EVEX |
| ext_r | output | 1 | R bit, already un-inverted |
| ext_x | output | 1 | X bit, already un-inverted |
| ext_b | output | 1 | B bit, already un-inverted |
| vvvv | output | 4 | Extra register specifier, un-inverted |
| vec_len | output | 2 | Vector length field |
| multi_pfx | output | 1 | A prefix group was repeated |
| bad_enc | output | 1 | Illegal prefix mix or map field |
| len_fault | output | 1 | 15 bytes consumed without an opcode |

## Verification
The hardest situations to reach from the ports are the ones that land exactly on the 15-byte limit: a lead byte or escape byte arriving as the 15th byte, and an opcode arriving as the 15th byte. Plain random streams almost never produce 14 prefixes in a row. Directed streams therefore pad with legacy prefixes up to the exact position, and the random generator sometimes emits long prefix runs. The look-ahead split outside long mode is biased by pairing each random lead byte half the time with a following byte whose top bits are 11. This makes both the VEX/EVEX branch and the LES/LDS/BOUND branch occur often while `in_valid` gaps are inserted at random.

// File: rtl/ihp_pkg.sv
package ihp_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] B_ESC  = 8'h0F;
  localparam logic [BYTE_W-1:0] B_E38  = 8'h38;
  localparam logic [BYTE_W-1:0] B_E3A  = 8'h3A;
  localparam logic [BYTE_W-1:0] B_VEX3 = 8'hC4;
  localparam logic [BYTE_W-1:0] B_VEX2 = 8'hC5;
  localparam logic [BYTE_W-1:0] B_EVEX = 8'h62;

  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_VEX    = 2'd1,
    ENC_EVEX   = 2'd2
  } enc_e;

  typedef enum logic [1:0] {
    MAP_ONE  = 2'd0,
    MAP_0F   = 2'd1,
    MAP_0F38 = 2'd2,
    MAP_0F3A = 2'd3
  } map_e;

  typedef enum logic [2:0] {
    ST_PFX, ST_ESC, ST_LEAD1, ST_VEX2, ST_EVEX1, ST_EVEX2, ST_OPC, ST_DONE
  } pstate_e;

  typedef struct packed {
    logic       lockrep;
    logic       seg;
    logic       opsz;
    logic       adsz;
    logic       rex;
    logic       esc;
    logic       lead;
    logic [1:0] lr_code;
    logic [2:0] seg_code;
  } bclass_t;
endpackage

// File: rtl/ihp_byte_class.sv
module ihp_byte_class
  import ihp_pkg::*;
(
  input  logic [BYTE_W-1:0] b,
  output bclass_t           cls
);
  always_comb begin
    cls = '0;
    case (b)
      8'hF0: begin cls.lockrep = 1'b1; cls.lr_code = 2'd1; end
      8'hF2: begin cls.lockrep = 1'b1; cls.lr_code = 2'd2; end
      8'hF3: begin cls.lockrep = 1'b1; cls.lr_code = 2'd3; end
      8'h26: begin cls.seg = 1'b1; cls.seg_code = 3'd1; end
      8'h2E: begin cls.seg = 1'b1; cls.seg_code = 3'd2; end
      8'h36: begin cls.seg = 1'b1; cls.seg_code = 3'd3; end
      8'h3E: begin cls.seg = 1'b1; cls.seg_code = 3'd4; end
      8'h64: begin cls.seg = 1'b1; cls.seg_code = 3'd5; end
      8'h65: begin cls.seg = 1'b1; cls.seg_code = 3'd6; end
      8'h66: cls.opsz = 1'b1;
      8'h67: cls.adsz = 1'b1;
      B_ESC: cls.esc = 1'b1;
      B_VEX3, B_VEX2, B_EVEX: cls.lead = 1'b1;
      default: cls.rex = (b[7:4] == 4'h4);
    endcase
  end
endmodule

// File: rtl/ihp_prefix_acc.sv
module ihp_prefix_acc (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       take,
  input  logic       is_lockrep,
  input  logic       is_seg,
  input  logic       is_opsz,
  input  logic       is_adsz,
  input  logic [1:0] lr_code,
  input  logic [2:0] seg_code,
  output logic [1:0] lockrep_sel,
  output logic [2:0] seg_sel,
  output logic       opsize_ovr,
  output logic       addrsize_ovr,
  output logic       multi_pfx
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lockrep_sel  <= '0;
      seg_sel      <= '0;
      opsize_ovr   <= 1'b0;
      addrsize_ovr <= 1'b0;
      multi_pfx    <= 1'b0;
    end else if (take) begin
      if (is_lockrep) begin
        lockrep_sel <= lr_code;
        if (lockrep_sel != '0) multi_pfx <= 1'b1;
      end
      if (is_seg) begin
        seg_sel <= seg_code;
        if (seg_sel != '0) multi_pfx <= 1'b1;
      end
      if (is_opsz) opsize_ovr <= 1'b1;
      if (is_adsz) addrsize_ovr <= 1'b1;
    end
  end
endmodule

// File: rtl/ihp_ctrl.sv
module ihp_ctrl
  import ihp_pkg::*;
#(
  parameter int MAX_LEN = 15,
  parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              long_mode,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              is_legacy,
  input  logic              is_rex,
  input  logic              is_esc,
  input  logic              is_lead,
  input  logic [1:0]        pfx_lockrep,
  input  logic              pfx_opsz,
  output logic              in_ready,
  output logic              pfx_take,
  output logic              done,
  output logic [BYTE_W-1:0] opcode,
  output logic [1:0]        op_map,
  output logic [1:0]        enc_kind,
  output logic [CNT_W-1:0]  byte_count,
  output logic              modrm_taken,
  output logic              rex_present,
  output logic              ext_w,
  output logic              ext_r,
  output logic              ext_x,
  output logic              ext_b,
  output logic [3:0]        vvvv,
  output logic [1:0]        vec_len,
  output logic              bad_enc,
  output logic              len_fault
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LEN);

  pstate_e           st_q, st_d;
  logic [BYTE_W-1:0] lead_q, lead_d, op_q, op_d;
  logic              peek_q, peek_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        map_q, map_d, enc_q, enc_d, vl_q, vl_d;
  logic [3:0]        vv_q, vv_d;
  logic              rex_q, rex_d, w_q, w_d, r_q, r_d, x_q, x_d, b_q, b_d;
  logic              mt_q, mt_d, bad_q, bad_d, lf_q, lf_d;
  logic              accept, fin, peek_fin;

  assign accept   = in_valid && (st_q != ST_DONE);
  assign in_ready = (st_q != ST_DONE);
  assign done     = (st_q == ST_DONE);
  assign pfx_take = accept && (st_q == ST_PFX) && is_legacy;

  always_comb begin
    st_d = st_q;  lead_d = lead_q; op_d = op_q; peek_d = peek_q; cnt_d = cnt_q;
    map_d = map_q; enc_d = enc_q; vl_d = vl_q; vv_d = vv_q;
    rex_d = rex_q; w_d = w_q; r_d = r_q; x_d = x_q; b_d = b_q;
    mt_d = mt_q; bad_d = bad_q; lf_d = lf_q;
    fin = 1'b0;
    peek_fin = 1'b0;
    if (st_q == ST_DONE) begin
      st_d = ST_PFX; lead_d = '0; op_d = '0; peek_d = 1'b0; cnt_d = '0;
      map_d = MAP_ONE; enc_d = ENC_LEGACY; vl_d = '0; vv_d = '0;
      rex_d = 1'b0; w_d = 1'b0; r_d = 1'b0; x_d = 1'b0; b_d = 1'b0;
      mt_d = 1'b0; bad_d = 1'b0; lf_d = 1'b0;
    end else if (accept) begin
      case (st_q)
        ST_PFX: begin
          if (is_legacy) begin
            rex_d = 1'b0; w_d = 1'b0; r_d = 1'b0; x_d = 1'b0; b_d = 1'b0;
          end else if (is_rex && long_mode) begin
            rex_d = 1'b1;
            {w_d, r_d, x_d, b_d} = in_byte[3:0];
          end else if (is_esc) begin
            map_d = MAP_0F;
            st_d  = ST_ESC;
          end else if (is_lead) begin
            lead_d = in_byte;
            peek_d = !long_mode;
            st_d   = ST_LEAD1;
          end else begin
            op_d = in_byte;
            fin  = 1'b1;
          end
        end
        ST_ESC: begin
          if (in_byte == B_E38) begin
            map_d = MAP_0F38; st_d = ST_OPC;
          end else if (in_byte == B_E3A) begin
            map_d = MAP_0F3A; st_d = ST_OPC;
          end else begin
            op_d = in_byte; fin = 1'b1;
          end
        end
        ST_LEAD1: begin
          if (peek_q && (in_byte[7:6] != 2'b11)) begin
            peek_fin = 1'b1;
            fin      = 1'b1;
            op_d     = lead_q;
            map_d    = MAP_ONE;
            mt_d     = 1'b1;
          end else begin
            bad_d = bad_q | rex_q | (pfx_lockrep != 2'd0) | pfx_opsz;
            r_d   = ~in_byte[7];
            w_d   = 1'b0;
            if (lead_q == B_VEX2) begin
              enc_d = ENC_VEX;
              x_d   = 1'b0;
              b_d   = 1'b0;
              vv_d  = ~in_byte[6:3];
              vl_d  = {1'b0, in_byte[2]};
              map_d = MAP_0F;
              st_d  = ST_OPC;
            end else if (lead_q == B_VEX3) begin
              enc_d = ENC_VEX;
              x_d   = ~in_byte[6];
              b_d   = ~in_byte[5];
              map_d = in_byte[1:0];
              if ((in_byte[4:0] == 5'd0) || (in_byte[4:0] > 5'd3)) bad_d = 1'b1;
              st_d  = ST_VEX2;
            end else begin
              enc_d = ENC_EVEX;
              x_d   = ~in_byte[6];
              b_d   = ~in_byte[5];
              map_d = in_byte[1:0];
              if (in_byte[1:0] == 2'd0) bad_d = 1'b1;
              st_d  = ST_EVEX1;
            end
          end
        end
        ST_VEX2: begin
          w_d  = in_byte[7];
          vv_d = ~in_byte[6:3];
          vl_d = {1'b0, in_byte[2]};
          st_d = ST_OPC;
        end
        ST_EVEX1: begin
          w_d  = in_byte[7];
          vv_d = ~in_byte[6:3];
          st_d = ST_EVEX2;
        end
        ST_EVEX2: begin
          vl_d = in_byte[6:5];
          st_d = ST_OPC;
        end
        default: begin
          op_d = in_byte;
          fin  = 1'b1;
        end
      endcase
      if (!peek_fin) begin
        cnt_d = cnt_q + 1'b1;
        if (!fin && (cnt_d == LIMIT)) begin
          lf_d = 1'b1;
          fin  = 1'b1;
        end
      end
      if (fin) st_d = ST_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_PFX; lead_q <= '0; op_q <= '0; peek_q <= 1'b0; cnt_q <= '0;
      map_q <= MAP_ONE; enc_q <= ENC_LEGACY; vl_q <= '0; vv_q <= '0;
      rex_q <= 1'b0; w_q <= 1'b0; r_q <= 1'b0; x_q <= 1'b0; b_q <= 1'b0;
      mt_q <= 1'b0; bad_q <= 1'b0; lf_q <= 1'b0;
    end else begin
      st_q <= st_d; lead_q <= lead_d; op_q <= op_d; peek_q <= peek_d; cnt_q <= cnt_d;
      map_q <= map_d; enc_q <= enc_d; vl_q <= vl_d; vv_q <= vv_d;
      rex_q <= rex_d; w_q <= w_d; r_q <= r_d; x_q <= x_d; b_q <= b_d;
      mt_q <= mt_d; bad_q <= bad_d; lf_q <= lf_d;
    end
  end

  assign opcode      = op_q;
  assign op_map      = map_q;
  assign enc_kind    = enc_q;
  assign byte_count  = cnt_q;
  assign modrm_taken = mt_q;
  assign rex_present = rex_q;
  assign ext_w       = w_q;
  assign ext_r       = r_q;
  assign ext_x       = x_q;
  assign ext_b       = b_q;
  assign vvvv        = vv_q;
  assign vec_len     = vl_q;
  assign bad_enc     = bad_q;
  assign len_fault   = lf_q;
endmodule

// File: rtl/insn_head_parser.sv
module insn_head_parser
  import ihp_pkg::*;
#(
  parameter int MAX_LEN = 15,
  parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             long_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  output logic             done,
  output logic [7:0]       opcode,
  output logic [1:0]       op_map,
  output logic [1:0]       enc_kind,
  output logic [CNT_W-1:0] byte_count,
  output logic             modrm_taken,
  output logic [1:0]       lockrep_sel,
  output logic [2:0]       seg_sel,
  output logic             opsize_ovr,
  output logic             addrsize_ovr,
  output logic             rex_present,
  output logic             ext_w,
  output logic             ext_r,
  output logic             ext_x,
  output logic             ext_b,
  output logic [3:0]       vvvv,
  output logic [1:0]       vec_len,
  output logic             multi_pfx,
  output logic             bad_enc,
  output logic             len_fault
);
  bclass_t cls;
  logic    pfx_take;

  ihp_byte_class u_class (
    .b   (in_byte),
    .cls (cls)
  );

  ihp_prefix_acc u_pfx (
    .clk          (clk),
    .rst          (rst),
    .clr          (done),
    .take         (pfx_take),
    .is_lockrep   (cls.lockrep),
    .is_seg       (cls.seg),
    .is_opsz      (cls.opsz),
    .is_adsz      (cls.adsz),
    .lr_code      (cls.lr_code),
    .seg_code     (cls.seg_code),
    .lockrep_sel  (lockrep_sel),
    .seg_sel      (seg_sel),
    .opsize_ovr   (opsize_ovr),
    .addrsize_ovr (addrsize_ovr),
    .multi_pfx    (multi_pfx)
  );

  ihp_ctrl #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .long_mode   (long_mode),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .is_legacy   (cls.lockrep | cls.seg | cls.opsz | cls.adsz),
    .is_rex      (cls.rex),
    .is_esc      (cls.esc),
    .is_lead     (cls.lead),
    .pfx_lockrep (lockrep_sel),
    .pfx_opsz    (opsize_ovr),
    .in_ready    (in_ready),
    .pfx_take    (pfx_take),
    .done        (done),
    .opcode      (opcode),
    .op_map      (op_map),
    .enc_kind    (enc_kind),
    .byte_count  (byte_count),
    .modrm_taken (modrm_taken),
    .rex_present (rex_present),
    .ext_w       (ext_w),
    .ext_r       (ext_r),
    .ext_x       (ext_x),
    .ext_b       (ext_b),
    .vvvv        (vvvv),
    .vec_len     (vec_len),
    .bad_enc     (bad_enc),
    .len_fault   (len_fault)
  );
endmodule

// File: rtl/ihp_checker.sv
module ihp_checker #(
  parameter int MAX_LEN = 15,
  parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             long_mode,
  input logic             in_valid,
  input logic             in_ready,
  input logic             done,
  input logic [7:0]       opcode,
  input logic [1:0]       op_map,
  input logic [1:0]       enc_kind,
  input logic [CNT_W-1:0] byte_count,
  input logic             modrm_taken,
  input logic             rex_present,
  input logic             bad_enc,
  input logic             len_fault
);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1
  done_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(in_valid && in_ready));

  // R10
  len_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (done && len_fault) |-> (byte_count == CNT_W'(MAX_LEN)));

  // R11
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ((byte_count != '0) && (byte_count <= CNT_W'(MAX_LEN))));

  // R8
  lookahead_chk: assert property (@(posedge clk) disable iff (rst)
    (done && modrm_taken) |-> ((enc_kind == 2'd0) && (op_map == 2'd0) && !long_mode &&
      ((opcode == 8'hC4) || (opcode == 8'hC5) || (opcode == 8'h62))));

  // R4
  rex_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (done && rex_present) |-> long_mode);

  // R9
  rex_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (done && rex_present && (enc_kind != 2'd0)) |-> bad_enc);
endmodule

bind insn_head_parser ihp_checker #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .long_mode   (long_mode),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .done        (done),
  .opcode      (opcode),
  .op_map      (op_map),
  .enc_kind    (enc_kind),
  .byte_count  (byte_count),
  .modrm_taken (modrm_taken),
  .rex_present (rex_present),
  .bad_enc     (bad_enc),
  .len_fault   (len_fault)
);

// File: tb/insn_head_parser_test.sv
module insn_head_parser_test;
  typedef logic [7:0] bytes_t [0:19];
  typedef struct packed {
    logic [1:0] lr;
    logic [2:0] seg;
    logic       os, asz, multi, rex, w, r, x, b;
    logic [3:0] vv;
    logic [1:0] vl, map, kind;
    logic [7:0] op;
    logic       mt, bad, lf;
    logic [3:0] cnt;
  } res_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic long_mode = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, done, modrm_taken, opsize_ovr, addrsize_ovr, rex_present;
  logic ext_w, ext_r, ext_x, ext_b, multi_pfx, bad_enc, len_fault;
  logic [7:0] opcode;
  logic [1:0] op_map, enc_kind, lockrep_sel, vec_len;
  logic [3:0] byte_count, vvvv;
  logic [2:0] seg_sel;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  insn_head_parser uut (
    .clk(clk), .rst(rst), .long_mode(long_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .done(done), .opcode(opcode), .op_map(op_map), .enc_kind(enc_kind),
    .byte_count(byte_count), .modrm_taken(modrm_taken), .lockrep_sel(lockrep_sel),
    .seg_sel(seg_sel), .opsize_ovr(opsize_ovr), .addrsize_ovr(addrsize_ovr),
    .rex_present(rex_present), .ext_w(ext_w), .ext_r(ext_r), .ext_x(ext_x), .ext_b(ext_b),
    .vvvv(vvvv), .vec_len(vec_len), .multi_pfx(multi_pfx), .bad_enc(bad_enc),
    .len_fault(len_fault)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int lr_of(input logic [7:0] c);
    case (c) 8'hF0: return 1; 8'hF2: return 2; 8'hF3: return 3; default: return 0; endcase
  endfunction

  function automatic int seg_of(input logic [7:0] c);
    case (c)
      8'h26: return 1; 8'h2E: return 2; 8'h36: return 3;
      8'h3E: return 4; 8'h64: return 5; 8'h65: return 6;
      default: return 0;
    endcase
  endfunction

  // Expected result from the requirements, scanning the stream front to back.
  function automatic res_t model(input bytes_t by, input bit lm);
    res_t e;
    int n, p;
    logic [7:0] c, nx;
    bit stop;
    e = '0; n = 0; p = 0; stop = 0;
    while (!stop) begin
      c = by[p];
      if (lr_of(c) != 0) begin
        if (e.lr != 0) e.multi = 1;
        e.lr = 2'(lr_of(c)); e.rex = 0; {e.w, e.r, e.x, e.b} = '0;
      end else if (seg_of(c) != 0) begin
        if (e.seg != 0) e.multi = 1;
        e.seg = 3'(seg_of(c)); e.rex = 0; {e.w, e.r, e.x, e.b} = '0;
      end else if (c == 8'h66 || c == 8'h67) begin
        if (c == 8'h66) e.os = 1; else e.asz = 1;
        e.rex = 0; {e.w, e.r, e.x, e.b} = '0;
      end else if (lm && c[7:4] == 4'h4) begin
        e.rex = 1; {e.w, e.r, e.x, e.b} = c[3:0];
      end else stop = 1;
      if (!stop) begin
        p++; n++;
        if (n == 15) begin e.lf = 1; e.cnt = 15; return e; end
      end
    end
    c = by[p];
    if (c == 8'h0F) begin
      p++; n++;
      if (n == 15) begin e.lf = 1; e.cnt = 15; return e; end
      c = by[p];
      e.map = 1;
      if (c == 8'h38 || c == 8'h3A) begin
        e.map = (c == 8'h38) ? 2'd2 : 2'd3;
        p++; n++;
        if (n == 15) begin e.lf = 1; e.cnt = 15; return e; end
        c = by[p];
      end
    end else if (c == 8'hC4 || c == 8'hC5 || c == 8'h62) begin
      p++; n++;
      if (n == 15) begin e.lf = 1; e.cnt = 15; return e; end
      nx = by[p];
      if (!lm && nx[7:6] != 2'b11) begin
        e.op = c; e.mt = 1; e.cnt = 4'(n); return e;
      end
      e.bad = e.rex | (e.lr != 0) | e.os;
      e.r = ~nx[7]; e.w = 0;
      if (c == 8'hC5) begin
        e.kind = 1; e.x = 0; e.b = 0; e.vv = ~nx[6:3]; e.vl = {1'b0, nx[2]}; e.map = 1;
      end else begin
        e.kind = (c == 8'hC4) ? 2'd1 : 2'd2;
        e.x = ~nx[6]; e.b = ~nx[5]; e.map = nx[1:0];
        if (c == 8'hC4 && (nx[4:0] == 0 || nx[4:0] > 3)) e.bad = 1;
        if (c == 8'h62 && nx[1:0] == 0) e.bad = 1;
        p++; n++;
        if (n == 15) begin e.lf = 1; e.cnt = 15; return e; end
        nx = by[p];
        e.w = nx[7]; e.vv = ~nx[6:3];
        if (c == 8'hC4) e.vl = {1'b0, nx[2]};
        else begin
          p++; n++;
          if (n == 15) begin e.lf = 1; e.cnt = 15; return e; end
          nx = by[p];
          e.vl = nx[6:5];
        end
      end
      p++; n++;
      if (n == 15) begin e.lf = 1; e.cnt = 15; return e; end
      c = by[p];
    end
    e.op = c; n++; e.cnt = 4'(n);
    return e;
  endfunction

  task automatic run(input bytes_t by, input bit lm, output res_t got);
    res_t e;
    int idx = 0;
    int guard = 0;
    bit fin = 0;
    got = '0;
    @(negedge clk);
    long_mode = lm;
    while (!fin) begin
      if (done) begin
        got = '{lockrep_sel, seg_sel, opsize_ovr, addrsize_ovr, multi_pfx, rex_present,
                ext_w, ext_r, ext_x, ext_b, vvvv, vec_len, op_map, enc_kind, opcode,
                modrm_taken, bad_enc, len_fault, byte_count};
        chk("R1", "ready during done", 32'(in_ready), 32'd0);
        fin = 1;
      end else if (guard > 120) begin
        chk("R1", "done never seen", 32'd0, 32'd1);
        fin = 1;
      end else begin
        in_valid = ($urandom % 4) != 0;
        in_byte  = by[idx];
        if (in_valid && in_ready) idx++;
        guard++;
        @(negedge clk);
      end
    end
    in_valid = 0;
    e = model(by, lm);
    chk("R11", "accepted bytes", 32'(idx), 32'(e.cnt) + 32'(e.mt));
    chk("R10", "len_fault", 32'(got.lf), 32'(e.lf));
    chk("R11", "byte_count", 32'(got.cnt), 32'(e.cnt));
    chk("R2", "lockrep/seg", {got.lr, got.seg}, {e.lr, e.seg});
    chk("R3", "multi", 32'(got.multi), 32'(e.multi));
    if (!e.lf) begin
      chk("R2", "opsize/addrsize", {got.os, got.asz}, {e.os, e.asz});
      chk("R4", "rex wrxb", {got.rex, got.w, got.r, got.x, got.b},
          {e.rex, e.w, e.r, e.x, e.b});
      chk("R5", "opcode/map", {got.op, got.map}, {e.op, e.map});
      chk("R6", "kind/vvvv/len", {got.kind, got.vv, got.vl}, {e.kind, e.vv, e.vl});
      chk("R8", "modrm_taken", 32'(got.mt), 32'(e.mt));
      chk("R9", "bad_enc", 32'(got.bad), 32'(e.bad));
    end
  endtask

  function automatic bytes_t mk(input logic [7:0] a0, input logic [7:0] a1,
                                input logic [7:0] a2, input logic [7:0] a3,
                                input logic [7:0] a4, input logic [7:0] a5);
    bytes_t t;
    for (int i = 0; i < 20; i++) t[i] = 8'h90;
    t[0] = a0; t[1] = a1; t[2] = a2; t[3] = a3; t[4] = a4; t[5] = a5;
    return t;
  endfunction

  function automatic logic [7:0] pick_legacy(input int k);
    case (k % 11)
      0: return 8'hF0; 1: return 8'hF2; 2: return 8'hF3; 3: return 8'h2E;
      4: return 8'h36; 5: return 8'h3E; 6: return 8'h26; 7: return 8'h64;
      8: return 8'h65; 9: return 8'h66; default: return 8'h67;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    res_t g;
    bytes_t t;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R12 reset state
    chk("R12", "ready after reset", 32'(in_ready), 32'd1);
    chk("R12", "done after reset", 32'(done), 32'd0);

    // R5 escape maps
    run(mk(8'h66, 8'h67, 8'hF3, 8'h0F, 8'h38, 8'hF5), 1'b1, g);
    chk("R5", "0F38 map", 32'(g.map), 32'd2);
    run(mk(8'h0F, 8'h3A, 8'h0F, 8'h90, 8'h90, 8'h90), 1'b0, g);
    chk("R5", "0F3A map", 32'(g.map), 32'd3);
    run(mk(8'h0F, 8'hB8, 8'h90, 8'h90, 8'h90, 8'h90), 1'b1, g);
    chk("R5", "0F map opcode", {g.map, g.op}, {2'd1, 8'hB8});
    // R3 repeated groups
    run(mk(8'hF0, 8'hF2, 8'h2E, 8'h3E, 8'h90, 8'h90), 1'b0, g);
    chk("R3", "last kept", {g.lr, g.seg, g.multi}, {2'd2, 3'd4, 1'b1});
    // R4 REX handling
    run(mk(8'h48, 8'h89, 8'hC0, 8'h90, 8'h90, 8'h90), 1'b1, g);
    chk("R4", "rex.w long", {g.rex, g.w, g.op}, {1'b1, 1'b1, 8'h89});
    run(mk(8'h48, 8'h89, 8'hC0, 8'h90, 8'h90, 8'h90), 1'b0, g);
    chk("R4", "40-4F is opcode outside long", {g.rex, g.op, g.cnt}, {1'b0, 8'h48, 4'd1});
    run(mk(8'h4F, 8'h66, 8'h89, 8'h90, 8'h90, 8'h90), 1'b1, g);
    chk("R4", "rex discarded", {g.rex, g.r, g.b}, 3'd0);
    // R6 two-byte VEX
    run(mk(8'hC5, 8'hF8, 8'h77, 8'h90, 8'h90, 8'h90), 1'b1, g);
    chk("R6", "c5 decode", {g.kind, g.map, g.vv, g.op, g.cnt},
        {2'd1, 2'd1, 4'd0, 8'h77, 4'd3});
    // R7 three-byte VEX and EVEX
    run(mk(8'hC4, 8'hE2, 8'h7B, 8'hF5, 8'hC0, 8'h90), 1'b1, g);
    chk("R7", "c4 decode", {g.map, g.w, g.vv, g.r, g.op, g.cnt, g.bad},
        {2'd2, 1'b0, 4'd0, 1'b0, 8'hF5, 4'd4, 1'b0});
    run(mk(8'h62, 8'hF1, 8'h7C, 8'h48, 8'h58, 8'hC0), 1'b1, g);
    chk("R7", "evex decode", {g.kind, g.map, g.vl, g.op, g.cnt},
        {2'd2, 2'd1, 2'd2, 8'h58, 4'd5});
    run(mk(8'hC4, 8'hE7, 8'h7B, 8'hF5, 8'h90, 8'h90), 1'b1, g);
    chk("R7", "bad map field", 32'(g.bad), 32'd1);
    // R8 look-ahead outside long mode
    run(mk(8'hC4, 8'h06, 8'h90, 8'h90, 8'h90, 8'h90), 1'b0, g);
    chk("R8", "les", {g.op, g.mt, g.cnt, g.kind}, {8'hC4, 1'b1, 4'd1, 2'd0});
    run(mk(8'h2E, 8'h62, 8'h00, 8'h90, 8'h90, 8'h90), 1'b0, g);
    chk("R8", "bound", {g.op, g.mt, g.cnt}, {8'h62, 1'b1, 4'd2});
    run(mk(8'hC5, 8'hC0, 8'h77, 8'h90, 8'h90, 8'h90), 1'b0, g);
    chk("R8", "vex when mod 11", {g.kind, g.mt, g.op}, {2'd1, 1'b0, 8'h77});
    // R9 illegal mix
    run(mk(8'h66, 8'hC5, 8'hF8, 8'h77, 8'h90, 8'h90), 1'b1, g);
    chk("R9", "66 before vex", 32'(g.bad), 32'd1);
    run(mk(8'h67, 8'h2E, 8'hC5, 8'hF8, 8'h77, 8'h90), 1'b1, g);
    chk("R9", "67 and seg allowed", 32'(g.bad), 32'd0);
    run(mk(8'h41, 8'h62, 8'hF1, 8'h7C, 8'h48, 8'h58), 1'b1, g);
    chk("R9", "rex before evex", 32'(g.bad), 32'd1);
    // R10 length limit
    for (int i = 0; i < 20; i++) t[i] = 8'h66;
    run(t, 1'b1, g);
    chk("R10", "15 prefixes", {g.lf, g.cnt}, {1'b1, 4'd15});
    t[14] = 8'h90;
    run(t, 1'b1, g);
    chk("R10", "opcode at 15", {g.lf, g.cnt, g.op}, {1'b0, 4'd15, 8'h90});
    t[13] = 8'h0F; t[14] = 8'h05;
    run(t, 1'b0, g);
    chk("R10", "escape at 14", {g.lf, g.map}, {1'b0, 2'd1});
    t[13] = 8'h66; t[14] = 8'hC4;
    run(t, 1'b0, g);
    chk("R10", "lead at 15", 32'(g.lf), 32'd1);
    // R12 reset in the middle
    @(negedge clk);
    in_valid = 1; in_byte = 8'hF0;
    @(negedge clk);
    in_valid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R12", "ready after mid reset", 32'(in_ready), 32'd1);
    run(mk(8'h90, 8'h90, 8'h90, 8'h90, 8'h90, 8'h90), 1'b1, g);
    chk("R12", "prefix cleared", {g.lr, g.cnt}, {2'd0, 4'd1});

    // random streams
    for (int k = 0; k < 400; k++) begin
      int runlen;
      runlen = (($urandom % 8) == 0) ? 10 + int'($urandom % 6) : 0;
      for (int i = 0; i < 20; i++) begin
        int sel;
        sel = int'($urandom % 16);
        if (i < runlen) t[i] = pick_legacy(int'($urandom));
        else if (sel < 5) t[i] = pick_legacy(int'($urandom));
        else if (sel < 7) t[i] = 8'h40 | 8'($urandom % 16);
        else if (sel == 7) t[i] = 8'h0F;
        else if (sel == 8) t[i] = ($urandom % 2) ? 8'h38 : 8'h3A;
        else if (sel == 9) begin
          case ($urandom % 3) 0: t[i] = 8'hC4; 1: t[i] = 8'hC5; default: t[i] = 8'h62; endcase
        end else t[i] = 8'($urandom);
        if (i > 0 && (t[i-1] == 8'hC4 || t[i-1] == 8'hC5 || t[i-1] == 8'h62) &&
            ($urandom % 2)) t[i] = 8'hC0 | 8'($urandom % 64);
      end
      run(t, 1'($urandom % 2), g);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule